// File: doc/BRIEF.md
# Byte-Wide Packet Host Port

This block connects a device to a host over two separate byte lanes: an inbound lane that carries request packets from the host, and an outbound lane that carries response packets back. The outbound lane is a multidrop bus shared with other devices. Before it drives that bus the port raises a request, and it sends only while an external arbiter grants it the bus. Both lanes carry a data-valid qualifier, an end-of-packet marker on the final byte, and a stop line for flow control. The port drives stop on the inbound lane and obeys stop on the outbound lane. Apart from the port clock, the two lanes share nothing, so traffic can move in both directions at once.

Inbound bytes go into a small FIFO. A framer checks each packet's length and type, then executes it against a small register file that stands in as the transaction target. A write packet updates a register. A read packet produces a six-byte response. The port handles one transaction at a time. If a packet is malformed, or the sender did not honour flow control, the port discards it and pulses an error output. A grant that arrives while the port is not requesting the bus is an enumeration event: the port takes the byte on the inbound data lines as its device number.

Top module: `hpp_port`

## Requirements
- R1: While reset is asserted and afterwards, bus_req, tx_vld, err and dev_id are low or zero. rx_hold stays high until clk_ok has been sampled high at a clock edge.
- R2: A write packet updates register `addr` with the 32-bit value carried MSB first in bytes 2 to 5. The packet layout is: byte 0 = 8'h01, byte 1 = addr, bytes 2 to 5 = data.
- R3: A read packet (byte 0 = 8'h02, byte 1 = addr, followed by four bytes of any value) produces a six-byte response: 8'h82, addr, then the register value MSB first. tx_last is high only together with the sixth byte.
- R4: bus_req rises when a response is pending. tx_vld is high only while bus_gnt is high and tx_hold is low. bus_req falls in the cycle after the byte that carries tx_last.
- R5: rx_hold is high whenever the inbound FIFO (16 entries) holds 12 or more bytes, and low once the level drops below 12 after clk_ok has been seen.
- R6: A packet shorter than 6 bytes causes one err pulse and has no effect. Packets longer than 6 bytes are accepted, and the bytes after the sixth are ignored.
- R7: A packet is discarded with an err pulse if its last byte arrives while rx_hold is high, or if any of its bytes is lost because the FIFO is full.
- R8: A packet with a type byte other than 8'h01 or 8'h02, or with an addr of 8 or more, causes one err pulse and changes no register.
- R9: bus_gnt high in a cycle where bus_req is low loads rx_data into dev_id. A grant received while requesting leaves dev_id unchanged.
- R10: Inbound packets that arrive while a response is waiting for the bus are queued. They execute in arrival order once the response has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock shared by both lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ok | input | 1 | High once the internal clock is stable |
| rx_data | input | 8 | Inbound byte, and the device number during enumeration |
| rx_vld | input | 1 | Inbound byte qualifier |
| rx_last | input | 1 | Marks the final inbound byte of a packet |
| rx_hold | output | 1 | Inbound stop: asks the host to pause |
| tx_data | output | 8 | Outbound byte |
| tx_vld | output | 1 | Outbound byte qualifier |
| tx_last | output | 1 | Marks the final outbound byte |
| tx_hold | input | 1 | Outbound stop from the receiver |
| bus_req | output | 1 | Request for the shared outbound bus |
| bus_gnt | input | 1 | Grant from the arbiter |
| err | output | 1 | One-cycle fault pulse |
| dev_id | output | 8 | Device number latched at enumeration |

## Verification
A table of write and read packets of several lengths, types and addresses runs first. It separates accepted writes, read-backs, short packets, over-long packets, bad types and out-of-range addresses by checking the response bytes and counting err pulses. Directed sequences then withhold the grant so that the inbound FIFO fills. This shows the exact level at which rx_hold rises, a packet truncated by a full FIFO, a packet that ends under rx_hold, and the in-order execution of packets queued behind a pending response. Outbound stop inserted mid-response, and grants seen with and without a pending request, separate legal sending from enumeration.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  localparam int MIN_PKT_LEN = 6;
  localparam int RSP_LEN     = 6;
  localparam logic [7:0] TYPE_WR  = 8'h01;
  localparam logic [7:0] TYPE_RD  = 8'h02;
  localparam logic [7:0] TYPE_RSP = 8'h82;

  typedef struct packed {
    logic       bad;
    logic       last;
    logic [7:0] data;
  } rx_ent_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // True when the FIFO level has reached the stop mark.
  function automatic logic over_mark(input int unsigned level, input int unsigned mark);
    return level >= mark;
  endfunction

  // True when a packet whose last byte follows seen_before bytes is too short.
  function automatic logic too_short(input int unsigned seen_before);
    return (seen_before + 1) < MIN_PKT_LEN;
  endfunction

  // Byte idx of a read response.
  function automatic logic [7:0] rsp_byte(input int unsigned idx, input logic [7:0] addr,
                                          input logic [31:0] val);
    case (idx)
      0:       return TYPE_RSP;
      1:       return addr;
      2:       return val[31:24];
      3:       return val[23:16];
      4:       return val[15:8];
      5:       return val[7:0];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hpp_rx_fifo.sv
module hpp_rx_fifo
  import hpp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_ent_t       push_ent,
  input  logic          pop,
  input  logic          tag_tail,
  output rx_ent_t       head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);

  rx_ent_t       mem [DEPTH];
  logic [PW-1:0] wr_q;
  logic [PW-1:0] rd_q;
  logic [LW-1:0] lvl_q;
  logic          do_push;
  logic          do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_q] <= push_ent;
    end
    if (tag_tail) begin
      mem[ptr_prev(wr_q)].last <= 1'b1;
      mem[ptr_prev(wr_q)].bad  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

endmodule

// File: rtl/hpp_rx_framer.sv
module hpp_rx_framer
  import hpp_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int AW = $clog2(NREGS),
  localparam int CW = $clog2(MIN_PKT_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rx_ent_t       head,
  input  logic          empty,
  input  logic          tx_idle,
  output logic          pop,
  output logic          fault,
  output logic          wr_en,
  output logic          rd_load,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    pkt_addr,
  output logic [31:0]   wr_data
);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          bad_q;
  logic [7:0]    type_q;
  logic [7:0]    addr_q;
  logic [31:0]   data_q;
  logic          known_type;
  logic          addr_ok;
  logic          accept;

  assign pop = !empty && !done_q && tx_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      type_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (pop) begin
        if (cnt_q == CW'(0)) begin
          type_q <= head.data;
        end else if (cnt_q == CW'(1)) begin
          addr_q <= head.data;
        end else if (cnt_q < CW'(MIN_PKT_LEN)) begin
          data_q <= {data_q[23:0], head.data};
        end
        if (head.last) begin
          done_q <= 1'b1;
          bad_q  <= head.bad || too_short(32'(cnt_q));
          cnt_q  <= '0;
        end else if (cnt_q != CW'(MIN_PKT_LEN)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign known_type = (type_q == TYPE_WR) || (type_q == TYPE_RD);
  assign addr_ok    = (32'(addr_q) < NREGS);
  assign accept     = done_q && !bad_q && known_type && addr_ok;
  assign fault      = done_q && !accept;
  assign wr_en      = accept && (type_q == TYPE_WR);
  assign rd_load    = accept && (type_q == TYPE_RD);
  assign reg_addr   = addr_q[AW-1:0];
  assign pkt_addr   = addr_q;
  assign wr_data    = data_q;

endmodule

// File: rtl/hpp_regfile.sv
module hpp_regfile #(
  parameter int NREGS = 8,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data
);

  logic [31:0] slot [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (wr_en && (addr == AW'(i))) begin
        slot[i] <= wr_data;
      end
    end
  end

  assign rd_data = slot[addr];

endmodule

// File: rtl/hpp_tx.sv
module hpp_tx
  import hpp_pkg::*;
#(
  localparam int IW = $clog2(RSP_LEN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  load_addr,
  input  logic [31:0] load_data,
  input  logic        gnt,
  input  logic        stop,
  output logic        req,
  output logic        vld,
  output logic        last,
  output logic [7:0]  data,
  output logic        idle
);

  tx_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    addr_q;
  logic [31:0]   data_q;
  logic          beat;
  logic          final_beat;

  assign beat       = (state_q == TX_SEND) && gnt && !stop;
  assign final_beat = beat && (idx_q == IW'(RSP_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (load) begin
          state_q <= TX_WAIT;
          addr_q  <= load_addr;
          data_q  <= load_data;
          idx_q   <= '0;
        end
        TX_WAIT: if (gnt) state_q <= TX_SEND;
        TX_SEND: if (final_beat) begin
          state_q <= TX_IDLE;
          idx_q   <= '0;
        end else if (beat) begin
          idx_q <= idx_q + 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req  = (state_q != TX_IDLE);
  assign idle = (state_q == TX_IDLE);
  assign vld  = beat;
  assign last = final_beat;
  assign data = beat ? rsp_byte(32'(idx_q), addr_q, data_q) : 8'h00;

endmodule

// File: rtl/hpp_port.sv
module hpp_port
  import hpp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int HOLD_MARK  = 12,
  parameter int NREGS      = 8,
  localparam int LW = $clog2(FIFO_DEPTH + 1),
  localparam int AW = $clog2(NREGS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ok,
  input  logic [7:0] rx_data,
  input  logic       rx_vld,
  input  logic       rx_last,
  output logic       rx_hold,
  output logic [7:0] tx_data,
  output logic       tx_vld,
  output logic       tx_last,
  input  logic       tx_hold,
  output logic       bus_req,
  input  logic       bus_gnt,
  output logic       err,
  output logic [7:0] dev_id
);

  logic          ready_q;
  logic          in_bad_q;
  logic          in_stored_q;
  logic          err_q;
  logic [7:0]    dev_id_q;

  rx_ent_t       push_ent;
  rx_ent_t       head;
  logic          fifo_empty;
  logic          fifo_full;
  logic [LW-1:0] rx_level;
  logic          rx_accept;
  logic          rx_drop;
  logic          tag_tail;
  logic          rx_lost;

  logic          pop;
  logic          frm_fault;
  logic          wr_en;
  logic          rd_load;
  logic [AW-1:0] reg_addr;
  logic [7:0]    pkt_addr;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic          tx_idle;
  logic          enum_evt;

  // Inbound flow control and packet tagging.
  assign rx_hold   = !ready_q || over_mark(32'(rx_level), HOLD_MARK);
  assign rx_accept = rx_vld && !fifo_full;
  assign rx_drop   = rx_vld && fifo_full;
  assign tag_tail  = rx_drop && rx_last && in_stored_q;
  assign rx_lost   = rx_drop && rx_last && !in_stored_q;

  always_comb begin
    push_ent      = '0;
    push_ent.data = rx_data;
    push_ent.last = rx_last;
    push_ent.bad  = rx_last && (in_bad_q || rx_hold);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      in_bad_q    <= 1'b0;
      in_stored_q <= 1'b0;
    end else begin
      if (clk_ok) ready_q <= 1'b1;
      if (rx_vld && rx_last) begin
        in_bad_q    <= 1'b0;
        in_stored_q <= 1'b0;
      end else begin
        if (rx_drop)   in_bad_q    <= 1'b1;
        if (rx_accept) in_stored_q <= 1'b1;
      end
    end
  end

  hpp_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rx_vld),
    .push_ent (push_ent),
    .pop      (pop),
    .tag_tail (tag_tail),
    .head     (head),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .level    (rx_level)
  );

  hpp_rx_framer #(.NREGS(NREGS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .head     (head),
    .empty    (fifo_empty),
    .tx_idle  (tx_idle),
    .pop      (pop),
    .fault    (frm_fault),
    .wr_en    (wr_en),
    .rd_load  (rd_load),
    .reg_addr (reg_addr),
    .pkt_addr (pkt_addr),
    .wr_data  (wr_data)
  );

  hpp_regfile #(.NREGS(NREGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (reg_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  hpp_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load),
    .load_addr (pkt_addr),
    .load_data (rd_data),
    .gnt       (bus_gnt),
    .stop      (tx_hold),
    .req       (bus_req),
    .vld       (tx_vld),
    .last      (tx_last),
    .data      (tx_data),
    .idle      (tx_idle)
  );

  // Enumeration: a grant that arrives while not requesting the bus.
  assign enum_evt = bus_gnt && !bus_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_id_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (enum_evt) dev_id_q <= rx_data;
      err_q <= frm_fault || rx_lost;
    end
  end

  assign dev_id = dev_id_q;
  assign err    = err_q;

endmodule

// File: rtl/hpp_port_chk.sv
module hpp_port_chk #(
  parameter int DEPTH = 16,
  parameter int MARK  = 12,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_ok,
  input logic [7:0]    rx_data,
  input logic          rx_hold,
  input logic          tx_vld,
  input logic          tx_last,
  input logic          tx_hold,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [7:0]    dev_id,
  input logic [LW-1:0] fifo_level
);

  logic seen_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_ok_q <= 1'b0;
    else if (clk_ok) seen_ok_q <= 1'b1;
  end

  // R1
  hold_until_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_ok_q |-> rx_hold);

  // R4
  send_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> (bus_gnt && bus_req && !tx_hold));

  // R4
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !bus_req);

  // R4
  req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !tx_last) |=> bus_req);

  // R3
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_vld);

  // R5
  hold_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_level) >= MARK) |-> rx_hold);

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= DEPTH);

  // R9
  enum_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && !bus_req) |=> (dev_id == $past(rx_data)));

  // R9
  enum_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req) |=> $stable(dev_id));

endmodule

bind hpp_port hpp_port_chk #(.DEPTH(FIFO_DEPTH), .MARK(HOLD_MARK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_ok     (clk_ok),
  .rx_data    (rx_data),
  .rx_hold    (rx_hold),
  .tx_vld     (tx_vld),
  .tx_last    (tx_last),
  .tx_hold    (tx_hold),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .dev_id     (dev_id),
  .fifo_level (rx_level)
);

// File: tb/sim_hpp_port.sv
module sim_hpp_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ok = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_vld = 1'b0;
  logic       rx_last = 1'b0;
  logic       rx_hold;
  logic [7:0] tx_data;
  logic       tx_vld;
  logic       tx_last;
  logic       tx_hold = 1'b0;
  logic       bus_req;
  logic       bus_gnt = 1'b0;
  logic       err;
  logic [7:0] dev_id;

  int n_chk = 0;
  int n_bad = 0;
  int err_seen = 0;
  int cyc = 0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  hpp_port u0 (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok),
    .rx_data(rx_data), .rx_vld(rx_vld), .rx_last(rx_last), .rx_hold(rx_hold),
    .tx_data(tx_data), .tx_vld(tx_vld), .tx_last(tx_last), .tx_hold(tx_hold),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .err(err), .dev_id(dev_id)
  );

  // op[45:44] 0=write 1=read 2=bad type, addr[43:36], data[35:4], len[3:0]
  localparam logic [45:0] VEC [11] = '{
    {2'd0, 8'h00, 32'hDEADBEEF, 4'd6},
    {2'd0, 8'h07, 32'h01234567, 4'd6},
    {2'd1, 8'h00, 32'h00000000, 4'd6},
    {2'd1, 8'h07, 32'h00000000, 4'd8},
    {2'd0, 8'h03, 32'hA5A5A5A5, 4'd5},
    {2'd1, 8'h03, 32'h00000000, 4'd6},
    {2'd0, 8'h09, 32'h11111111, 4'd6},
    {2'd2, 8'h02, 32'h22222222, 4'd6},
    {2'd0, 8'h03, 32'h5A5A0F0F, 4'd7},
    {2'd1, 8'h03, 32'h00000000, 4'd6},
    {2'd1, 8'h01, 32'h00000000, 4'd1}
  };

  always @(negedge clk) if (rst_n && err) err_seen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(input logic [1:0] op, input logic [7:0] addr,
                                          input logic [31:0] d, input int i);
    case (i)
      0: return (op == 2'd0) ? 8'h01 : (op == 2'd1) ? 8'h02 : 8'h33;
      1: return addr;
      2: return d[31:24];
      3: return d[23:16];
      4: return d[15:8];
      5: return d[7:0];
      default: return 8'hEE;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    rx_data = d; rx_vld = 1'b1; rx_last = l;
    @(negedge clk);
    rx_vld = 1'b0; rx_last = 1'b0; rx_data = 8'h00;
  endtask

  task automatic send_pkt(input logic [1:0] op, input logic [7:0] addr,
                          input logic [31:0] d, input int len);
    for (int i = 0; i < len; i++) send_byte(pkt_byte(op, addr, d, i), i == len - 1);
  endtask

  // Acts as arbiter and receiver for one response.
  task automatic collect(input int hold_at, output logic [47:0] got, output int nb,
                         output int lastpos, output int viol);
    int w = 0;
    int hl = 0;
    bit used = 0;
    got = '0; nb = 0; lastpos = 0; viol = 0;
    while (!bus_req && w < 200) begin @(negedge clk); w++; end
    if (!bus_req) return;
    bus_gnt = 1'b1;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (tx_vld) begin
        if (tx_hold) viol++;
        got = {got[39:0], tx_data};
        nb++;
        if (tx_last) lastpos = nb;
      end
      if (tx_vld && tx_last) break;
      if (tx_hold) begin
        hl--;
        if (tx_vld) viol++;
        if (hl == 0) tx_hold = 1'b0;
      end else if (!used && nb == hold_at) begin
        tx_hold = 1'b1; hl = 2; used = 1;
      end
    end
    @(negedge clk);
    chk({63'd0, bus_req}, 64'd0, "R4 request drops after last byte");
    bus_gnt = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    logic [47:0] got; int nb, lp, vi;
    send_pkt(2'd1, addr, 32'd0, 6);
    collect(-1, got, nb, lp, vi);
    chk({16'd0, got}, {16'd0, 8'h82, addr, exp}, tag);
  endtask

  initial begin
    logic [47:0] got;
    int nb, lp, vi, e0;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({59'd0, rx_hold, bus_req, tx_vld, err, 1'b0}, {59'd0, 5'b10000}, "R1 reset outputs");
    chk({56'd0, dev_id}, 64'd0, "R1 dev_id after reset");
    repeat (4) @(negedge clk);
    chk({63'd0, rx_hold}, 64'd1, "R1 hold before clk_ok");
    clk_ok = 1'b1;
    @(negedge clk);
    chk({63'd0, rx_hold}, 64'd0, "R1 hold released after clk_ok");

    // R9 enumeration
    bus_gnt = 1'b1; rx_data = 8'h2C;
    @(negedge clk);
    bus_gnt = 1'b0; rx_data = 8'h00;
    chk({56'd0, dev_id}, 64'h2C, "R9 device number latched");

    // Table walk: R2 R3 R6 R8
    foreach (VEC[k]) begin
      logic [1:0] op; logic [7:0] a; logic [31:0] d; int len; bit e_exp;
      op = VEC[k][45:44]; a = VEC[k][43:36]; d = VEC[k][35:4]; len = int'(VEC[k][3:0]);
      e_exp = (len < 6) || (op == 2'd2) || (a >= 8);
      e0 = err_seen;
      send_pkt(op, a, d, len);
      if (!e_exp && op == 2'd1) begin
        collect(-1, got, nb, lp, vi);
        chk({16'd0, got}, {16'd0, 8'h82, a, model[a[2:0]]}, "R3 R2 read response");
        chk(64'(lp), 64'd6, "R3 last on sixth byte");
      end else begin
        repeat (10) @(negedge clk);
        chk({63'd0, bus_req}, 64'd0, "R6 R8 no response");
        if (!e_exp) model[a[2:0]] = d;
      end
      repeat (4) @(negedge clk);
      chk(64'(err_seen - e0), e_exp ? 64'd1 : 64'd0, "R6 R8 error pulse count");
    end

    // R5 R7 R10: fill the FIFO behind a pending response
    e0 = err_seen;
    send_pkt(2'd1, 8'h00, 32'd0, 6);
    while (!bus_req) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk({63'd0, tx_vld}, 64'd0, "R4 no send without grant");
    end
    send_pkt(2'd0, 8'h04, 32'h44444444, 6);
    for (int i = 0; i < 5; i++) send_byte(pkt_byte(2'd0, 8'h05, 32'h55555555, i), 1'b0);
    chk({63'd0, rx_hold}, 64'd0, "R5 hold low at 11 bytes");
    send_byte(pkt_byte(2'd0, 8'h05, 32'h55555555, 5), 1'b1);
    chk({63'd0, rx_hold}, 64'd1, "R5 hold high at 12 bytes");
    send_pkt(2'd0, 8'h06, 32'h66666666, 6);
    collect(2, got, nb, lp, vi);
    chk({16'd0, got}, {16'd0, 8'h82, 8'h00, model[0]}, "R3 response under queue");
    chk(64'(vi), 64'd0, "R4 no valid during outbound stop");
    repeat (40) @(negedge clk);
    chk(64'(err_seen - e0), 64'd1, "R7 truncated packet flagged");
    chk({63'd0, rx_hold}, 64'd0, "R5 hold drops after drain");
    model[4] = 32'h44444444; model[5] = 32'h55555555;
    do_read(8'h04, model[4], "R10 queued write one");
    do_read(8'h05, model[5], "R10 queued write two");
    do_read(8'h06, model[6], "R7 truncated packet had no effect");

    // R7: packet ending while hold is high; R9 grant while requesting
    e0 = err_seen;
    send_pkt(2'd1, 8'h00, 32'd0, 6);
    send_pkt(2'd0, 8'h01, 32'h11112222, 6);
    send_pkt(2'd0, 8'h02, 32'h77777777, 8);
    rx_data = 8'h99;
    collect(-1, got, nb, lp, vi);
    rx_data = 8'h00;
    chk({56'd0, dev_id}, 64'h2C, "R9 grant while requesting ignored");
    repeat (40) @(negedge clk);
    chk(64'(err_seen - e0), 64'd1, "R7 end under hold flagged");
    model[1] = 32'h11112222;
    do_read(8'h01, model[1], "R10 write before flagged packet");
    do_read(8'h02, model[2], "R7 packet under hold had no effect");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule